// File: doc/BRIEF.md
# DMA Command Queue with Tag-Group Completion

This block sits in front of a memory transfer engine. Software places transfer commands into a bounded first-in first-out queue. Each command names a direction, a local buffer address, a system memory address, a byte count and a 5-bit group tag. The queue hands the commands to the engine one at a time over a valid/ready handshake, in the order they arrived. The transfer itself happens in the engine.

Every one of the 32 tag groups has an outstanding counter. The counter rises when a command with that tag is accepted and falls when the engine reports a finished transfer for that tag. Software writes a 32-bit selection mask and then reads a status word. A status bit is 1 when the mask enables that group and the group has nothing outstanding.

A status read works in one of two modes. An immediate read answers on the next cycle. A wait-all read answers only once every enabled group has drained. The read control is a two-state machine. In ST_IDLE it accepts a read. It moves to ST_WAIT when the read is a wait-all and some enabled group is still busy. In every other case it answers directly and stays in ST_IDLE. In ST_WAIT it stays put while any enabled group is busy. It returns to ST_IDLE, with its answer, once none are.

Top module: `dmaq_top`

## Requirements
- R1: The queue holds at most 16 commands. While 16 are held, `enq_ready` is low and no further command is accepted.
- R2: Commands leave on `iss_*` in arrival order with every field unchanged. `iss_dir` 0 means get (system to local) and 1 means put (local to system). While `iss_valid` is high and `iss_ready` is low, the presented command stays stable.
- R3: A group's outstanding count rises by one for each accepted command carrying that tag. It falls by one for each `done_valid` pulse carrying that tag. When both happen for the same tag in the same cycle, the count is unchanged.
- R4: A `done_valid` pulse for a group whose count is zero has no effect.
- R5: `mask_we` loads `mask_wdata` into the 32-bit mask, with bit i selecting group i. Status bit i is 1 exactly when mask bit i is 1 and group i has a count of zero.
- R6: A read with `rd_wait_all` low, issued while no read is pending, raises `rd_valid` for one cycle on the next cycle, carrying the status word.
- R7: A read with `rd_wait_all` high keeps `rd_valid` low while any enabled group is nonzero. It responds one cycle after the last enabled group reaches zero, and the status word then equals the mask.
- R8: A wait-all read issued while the mask is zero responds on the next cycle with all zeros, whatever is outstanding.
- R9: A command whose tag's count is at its maximum of 31 is refused (`enq_ready` low). Commands with other tags are still accepted.
- R10: After reset the queue is empty, all counts are zero, the mask is zero and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Command offered |
| enq_ready | output | 1 | Command can be accepted |
| enq_dir | input | 1 | 0 get, 1 put |
| enq_laddr | input | 18 | Local buffer address |
| enq_saddr | input | 32 | System memory address |
| enq_size | input | 15 | Byte count |
| enq_tag | input | 5 | Group tag |
| iss_valid | output | 1 | Head command available to engine |
| iss_ready | input | 1 | Engine takes head command |
| iss_dir | output | 1 | Head direction |
| iss_laddr | output | 18 | Head local address |
| iss_saddr | output | 32 | Head system address |
| iss_size | output | 15 | Head byte count |
| iss_tag | output | 5 | Head group tag |
| done_valid | input | 1 | Engine finished a transfer |
| done_tag | input | 5 | Tag of finished transfer |
| mask_we | input | 1 | Load selection mask |
| mask_wdata | input | 32 | New mask value |
| rd_req | input | 1 | Status read request (one-cycle pulse) |
| rd_wait_all | input | 1 | Read waits for all enabled groups |
| rd_valid | output | 1 | Status word valid |
| rd_data | output | 32 | Status word |

## Verification
The assertions assume that `rd_req` is pulsed only while the read control is in ST_IDLE. They also assume that the engine reports a completion only for a tag it has actually taken from the queue. The bench waits for each `rd_valid` before it issues the next read. It sends `done_valid` only for tags it has enqueued, except in the R4 case, which deliberately targets an empty group. The checker keeps its own occupancy count from the two handshakes, so the full-queue property does not depend on the queue's internal counter.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
    parameter int QDEPTH   = 16;
    parameter int TAG_W    = 5;
    parameter int NTAGS    = 1 << TAG_W;
    parameter int LADDR_W  = 18;
    parameter int SADDR_W  = 32;
    parameter int SIZE_W   = 15;
    parameter int CNT_W    = 5;

    typedef struct packed {
        logic               dir;
        logic [LADDR_W-1:0] laddr;
        logic [SADDR_W-1:0] saddr;
        logic [SIZE_W-1:0]  size;
        logic [TAG_W-1:0]   tag;
    } cmd_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } rd_state_e;
endpackage

// File: rtl/dmaq_fifo.sv
module dmaq_fifo
    import dmaq_pkg::*;
#(
    parameter int DEPTH = QDEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  cmd_t push_cmd,
    output logic not_full,
    input  logic pop,
    output logic not_empty,
    output cmd_t head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

    cmd_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [OCC_W-1:0] occ;
    logic             do_push, do_pop;

    assign not_full  = (occ != FULL);
    assign not_empty = (occ != '0);
    assign do_push   = push && not_full;
    assign do_pop    = pop && not_empty;
    assign head      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_cmd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      occ <= occ + 1'b1;
            else if (do_pop && !do_push) occ <= occ - 1'b1;
        end
    end
endmodule

// File: rtl/dmaq_tag_track.sv
module dmaq_tag_track
    import dmaq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_valid,
    input  logic [TAG_W-1:0] inc_tag,
    input  logic             dec_valid,
    input  logic [TAG_W-1:0] dec_tag,
    output logic [NTAGS-1:0] busy,
    output logic [NTAGS-1:0] sat
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    for (genvar g = 0; g < NTAGS; g++) begin : g_grp
        logic [CNT_W-1:0] cnt;
        logic             inc, dec;

        assign inc = inc_valid && (inc_tag == TAG_W'(g));
        assign dec = dec_valid && (dec_tag == TAG_W'(g)) && (cnt != '0);

        always_ff @(posedge clk) begin
            if (!rst_n)           cnt <= '0;
            else if (inc && !dec) cnt <= cnt + 1'b1;
            else if (dec && !inc) cnt <= cnt - 1'b1;
        end

        assign busy[g] = (cnt != '0);
        assign sat[g]  = (cnt == CNT_MAX);
    end
endmodule

// File: rtl/dmaq_rd_fsm.sv
module dmaq_rd_fsm
    import dmaq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic             rd_wait_all,
    input  logic [NTAGS-1:0] mask,
    input  logic [NTAGS-1:0] busy,
    output logic             rd_valid,
    output logic [NTAGS-1:0] rd_data,
    output logic             idle
);
    rd_state_e        st, st_nxt;
    logic             pending;
    logic [NTAGS-1:0] status;

    assign pending = |(mask & busy);
    assign status  = mask & ~busy;
    assign idle    = (st == ST_IDLE);

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (rd_req && rd_wait_all && pending) st_nxt = ST_WAIT;
            ST_WAIT: if (!pending) st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            unique case (st)
                ST_IDLE: if (rd_req && !(rd_wait_all && pending)) begin
                    rd_valid <= 1'b1;
                    rd_data  <= status;
                end
                ST_WAIT: if (!pending) begin
                    rd_valid <= 1'b1;
                    rd_data  <= status;
                end
            endcase
        end
    end
endmodule

// File: rtl/dmaq_top.sv
module dmaq_top
    import dmaq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enq_valid,
    output logic               enq_ready,
    input  logic               enq_dir,
    input  logic [LADDR_W-1:0] enq_laddr,
    input  logic [SADDR_W-1:0] enq_saddr,
    input  logic [SIZE_W-1:0]  enq_size,
    input  logic [TAG_W-1:0]   enq_tag,
    output logic               iss_valid,
    input  logic               iss_ready,
    output logic               iss_dir,
    output logic [LADDR_W-1:0] iss_laddr,
    output logic [SADDR_W-1:0] iss_saddr,
    output logic [SIZE_W-1:0]  iss_size,
    output logic [TAG_W-1:0]   iss_tag,
    input  logic               done_valid,
    input  logic [TAG_W-1:0]   done_tag,
    input  logic               mask_we,
    input  logic [NTAGS-1:0]   mask_wdata,
    input  logic               rd_req,
    input  logic               rd_wait_all,
    output logic               rd_valid,
    output logic [NTAGS-1:0]   rd_data
);
    cmd_t             in_cmd, head;
    logic             q_not_full, enq_fire;
    logic [NTAGS-1:0] busy, sat, mask_q;
    logic             rd_idle;

    assign in_cmd    = '{dir: enq_dir, laddr: enq_laddr, saddr: enq_saddr,
                         size: enq_size, tag: enq_tag};
    assign enq_ready = q_not_full && !sat[enq_tag];
    assign enq_fire  = enq_valid && enq_ready;

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    dmaq_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (enq_fire),
        .push_cmd  (in_cmd),
        .not_full  (q_not_full),
        .pop       (iss_ready),
        .not_empty (iss_valid),
        .head      (head)
    );

    assign iss_dir   = head.dir;
    assign iss_laddr = head.laddr;
    assign iss_saddr = head.saddr;
    assign iss_size  = head.size;
    assign iss_tag   = head.tag;

    dmaq_tag_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_valid (enq_fire),
        .inc_tag   (enq_tag),
        .dec_valid (done_valid),
        .dec_tag   (done_tag),
        .busy      (busy),
        .sat       (sat)
    );

    dmaq_rd_fsm u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (rd_req),
        .rd_wait_all (rd_wait_all),
        .mask        (mask_q),
        .busy        (busy),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .idle        (rd_idle)
    );
endmodule

// File: rtl/dmaq_checker.sv
module dmaq_checker
    import dmaq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               enq_valid,
    input logic               enq_ready,
    input logic               iss_valid,
    input logic               iss_ready,
    input logic [TAG_W-1:0]   iss_tag,
    input logic [LADDR_W-1:0] iss_laddr,
    input logic [SADDR_W-1:0] iss_saddr,
    input logic               rd_req,
    input logic               rd_wait_all,
    input logic               rd_valid,
    input logic [NTAGS-1:0]   rd_data,
    input logic [NTAGS-1:0]   mask_q,
    input logic               rd_idle
);
    localparam int OCC_W = $clog2(QDEPTH + 1) + 1;

    logic [OCC_W-1:0] occ;
    logic             wait_mode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ       <= '0;
            wait_mode <= 1'b0;
        end else begin
            occ <= occ + OCC_W'(enq_valid && enq_ready) - OCC_W'(iss_valid && iss_ready);
            if (rd_req && rd_idle) wait_mode <= rd_wait_all;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(QDEPTH)); // R1
    AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_W'(QDEPTH)) |-> !enq_ready); // R1
    AST_ISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_tag)
            && $stable(iss_laddr) && $stable(iss_saddr))); // R2
    AST_STATUS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data & ~$past(mask_q)) == '0)); // R5
    AST_IMM_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_idle && !rd_wait_all) |=> rd_valid); // R6
    AST_WAIT_ALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && wait_mode) |-> (rd_data == $past(mask_q))); // R7
endmodule

bind dmaq_top dmaq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enq_valid   (enq_valid),
    .enq_ready   (enq_ready),
    .iss_valid   (iss_valid),
    .iss_ready   (iss_ready),
    .iss_tag     (iss_tag),
    .iss_laddr   (iss_laddr),
    .iss_saddr   (iss_saddr),
    .rd_req      (rd_req),
    .rd_wait_all (rd_wait_all),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .mask_q      (mask_q),
    .rd_idle     (rd_idle)
);

// File: tb/dmaq_top_tb.sv
module dmaq_top_tb_top;
    import dmaq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_ENQ = 2'd0, OP_DONE = 2'd1, OP_MASK = 2'd2, OP_READ = 2'd3;
    localparam int NVEC = 14;
    // {op, argument, expected status}
    localparam logic [65:0] VEC [NVEC] = '{
        {OP_MASK, 32'hFFFF_FFFF, 32'h0},
        {OP_READ, 32'h0,         32'hFFFF_FFFF},  // R5 all idle
        {OP_ENQ,  32'd7,         32'h0},
        {OP_READ, 32'h0,         32'hFFFF_FF7F},  // R3 group 7 busy
        {OP_ENQ,  32'd7,         32'h0},
        {OP_DONE, 32'd7,         32'h0},
        {OP_READ, 32'h0,         32'hFFFF_FF7F},  // R3 one still out
        {OP_DONE, 32'd7,         32'h0},
        {OP_READ, 32'h0,         32'hFFFF_FFFF},  // R3 drained
        {OP_DONE, 32'd7,         32'h0},          // R4 extra completion
        {OP_ENQ,  32'd0,         32'h0},
        {OP_MASK, 32'h0000_0081, 32'h0},
        {OP_READ, 32'h0,         32'h0000_0080},  // R5 filtered
        {OP_READ, 32'h0,         32'h0000_0080}   // R4 group 7 not underflowed
    };

    logic               clk = 1'b0, rst_n = 1'b0;
    logic               enq_valid = 1'b0, enq_dir = 1'b0;
    logic               enq_ready;
    logic [LADDR_W-1:0] enq_laddr = '0;
    logic [SADDR_W-1:0] enq_saddr = '0;
    logic [SIZE_W-1:0]  enq_size = '0;
    logic [TAG_W-1:0]   enq_tag = '0;
    logic               iss_valid, iss_ready = 1'b0, iss_dir;
    logic [LADDR_W-1:0] iss_laddr;
    logic [SADDR_W-1:0] iss_saddr;
    logic [SIZE_W-1:0]  iss_size;
    logic [TAG_W-1:0]   iss_tag;
    logic               done_valid = 1'b0;
    logic [TAG_W-1:0]   done_tag = '0;
    logic               mask_we = 1'b0;
    logic [NTAGS-1:0]   mask_wdata = '0;
    logic               rd_req = 1'b0, rd_wait_all = 1'b0, rd_valid;
    logic [NTAGS-1:0]   rd_data;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmaq_top dut_i (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic enq(input logic d, input logic [TAG_W-1:0] t, input logic [LADDR_W-1:0] la,
                       input logic [SADDR_W-1:0] sa, input logic [SIZE_W-1:0] sz);
        @(negedge clk);
        enq_valid = 1'b1; enq_dir = d; enq_tag = t; enq_laddr = la; enq_saddr = sa; enq_size = sz;
        @(posedge clk); #1 enq_valid = 1'b0;
    endtask

    task automatic done(input logic [TAG_W-1:0] t);
        @(negedge clk);
        done_valid = 1'b1; done_tag = t;
        @(posedge clk); #1 done_valid = 1'b0;
    endtask

    task automatic set_mask(input logic [31:0] m);
        @(negedge clk);
        mask_we = 1'b1; mask_wdata = m;
        @(posedge clk); #1 mask_we = 1'b0;
    endtask

    task automatic read_now(input logic w, output logic v, output logic [31:0] d);
        @(negedge clk);
        rd_req = 1'b1; rd_wait_all = w;
        @(posedge clk); #1 rd_req = 1'b0;
        v = rd_valid; d = rd_data;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic v;
        logic [31:0] d;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10 reset state
        chk("R10 enq_ready", enq_ready, 1);
        chk("R10 iss_valid", iss_valid, 0);
        chk("R10 rd_valid", rd_valid, 0);
        read_now(1'b0, v, d);
        chk("R10 mask zero status", {v, d}, {1'b1, 32'h0});

        // Vector table, engine always ready
        iss_ready = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            unique case (VEC[i][65:64])
                OP_ENQ:  enq(1'b0, VEC[i][36:32], '0, '0, 15'd16);
                OP_DONE: done(VEC[i][36:32]);
                OP_MASK: set_mask(VEC[i][63:32]);
                OP_READ: begin
                    read_now(1'b0, v, d);
                    chk($sformatf("R5 R6 vector %0d", i), {v, d}, {1'b1, VEC[i][31:0]});
                end
            endcase
        end
        done(5'd0);

        // R2 order, field integrity and hold
        iss_ready = 1'b0;
        enq(1'b0, 5'd1, 18'h0_1111, 32'hAAAA_0001, 15'd1);
        enq(1'b1, 5'd2, 18'h0_2222, 32'hBBBB_0002, 15'd16);
        enq(1'b1, 5'd3, 18'h0_3333, 32'hCCCC_0003, 15'd4096);
        @(negedge clk);
        chk("R2 head first", {iss_valid, iss_dir, iss_tag, iss_laddr, iss_saddr, iss_size},
            {1'b1, 1'b0, 5'd1, 18'h0_1111, 32'hAAAA_0001, 15'd1});
        @(negedge clk);
        chk("R2 head held", {iss_tag, iss_laddr}, {5'd1, 18'h0_1111});
        iss_ready = 1'b1; @(posedge clk); #1 iss_ready = 1'b0;
        chk("R2 second put", {iss_dir, iss_tag, iss_laddr, iss_saddr, iss_size},
            {1'b1, 5'd2, 18'h0_2222, 32'hBBBB_0002, 15'd16});
        iss_ready = 1'b1; @(posedge clk); #1 iss_ready = 1'b0;
        chk("R2 third put", {iss_dir, iss_tag, iss_laddr, iss_saddr, iss_size},
            {1'b1, 5'd3, 18'h0_3333, 32'hCCCC_0003, 15'd4096});
        iss_ready = 1'b1; @(posedge clk); #1;
        chk("R2 drained", iss_valid, 0);
        for (int t = 1; t <= 3; t++) done(5'(t));

        // R1 capacity
        iss_ready = 1'b0;
        for (int t = 0; t < 16; t++) enq(1'b0, 5'(t), 18'(t), 32'(t), 15'd8);
        @(negedge clk);
        enq_valid = 1'b1; enq_tag = 5'd20; #1;
        chk("R1 full refuses", enq_ready, 0);
        @(posedge clk); #1 enq_valid = 1'b0;
        iss_ready = 1'b1; @(posedge clk); #1 iss_ready = 1'b0;
        chk("R1 space after pop", enq_ready, 1);
        chk("R1 refused cmd not queued", iss_tag, 5'd1);
        iss_ready = 1'b1; repeat (15) @(posedge clk); #1;
        chk("R1 sixteen drained", iss_valid, 0);
        set_mask(32'h0010_0000);
        read_now(1'b0, v, d);
        chk("R1 refused tag not counted", d, 32'h0010_0000);
        for (int t = 0; t < 16; t++) done(5'(t));

        // R3 simultaneous enqueue and completion
        set_mask(32'h0000_0020);
        enq(1'b0, 5'd5, '0, '0, 15'd2);
        @(negedge clk);
        enq_valid = 1'b1; enq_tag = 5'd5; done_valid = 1'b1; done_tag = 5'd5;
        @(posedge clk); #1 enq_valid = 1'b0; done_valid = 1'b0;
        read_now(1'b0, v, d);
        chk("R3 same-cycle unchanged", d, 32'h0);
        done(5'd5);
        read_now(1'b0, v, d);
        chk("R3 back to zero", d, 32'h0000_0020);

        // R7 wait-all
        enq(1'b0, 5'd9, '0, '0, 15'd2);
        enq(1'b1, 5'd10, '0, '0, 15'd2);
        set_mask(32'h0000_0600);
        read_now(1'b1, v, d);
        chk("R7 held while busy", v, 0);
        repeat (3) @(posedge clk); #1;
        chk("R7 still held", rd_valid, 0);
        done(5'd9);
        chk("R7 held one group left", rd_valid, 0);
        done(5'd10);
        chk("R7 not yet on clear edge", rd_valid, 0);
        @(posedge clk); #1;
        chk("R7 answers after drain", {rd_valid, rd_data}, {1'b1, 32'h0000_0600});

        // R8 zero mask wait-all answers at once
        enq(1'b0, 5'd2, '0, '0, 15'd2);
        set_mask(32'h0);
        read_now(1'b1, v, d);
        chk("R8 zero mask immediate", {v, d}, {1'b1, 32'h0});
        done(5'd2);

        // R9 counter saturation
        for (int k = 0; k < 31; k++) enq(1'b0, 5'd3, '0, '0, 15'd1);
        @(negedge clk);
        enq_valid = 1'b1; enq_tag = 5'd3; #1;
        chk("R9 saturated tag refused", enq_ready, 0);
        enq_tag = 5'd4; #1;
        chk("R9 other tag accepted", enq_ready, 1);
        enq_valid = 1'b0;
        done(5'd3);
        @(negedge clk);
        enq_tag = 5'd3; #1;
        chk("R9 accepts after completion", enq_ready, 1);
        for (int k = 0; k < 30; k++) done(5'd3);

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule